// File: doc/BRIEF.md
# Startup Handshake and SPI Ownership Controller

This block sequences the power-up exchange between a host and an embedded configuration engine that share one SPI master. The engine uses that master to set up two retimers of four links each with a forward-error-correction mode. The host then takes the master over. The host reaches the block through a small register window on the internal bus. An init word carries a done flag, a start request and eight 2-bit FEC requests, one per link. A version word describes the engine firmware. Two status words, one per retimer, report the outcome of the setup.

The firmware version is sampled while reset is held, and it selects one of three start-up behaviours. With an all-zero version there is no firmware, and the host owns the master at once. With a major version of 3 or more, the engine waits for the host to write the start bit. With any older nonzero version, the engine runs without being asked. When the engine signals completion, the done flag sets and stays set. The ownership select then switches the SPI mux to the host, whether or not a status word reports an error. The engine is modelled at this block's edge by a run level, a done pulse and a status-load strobe.

Top module: `hs_own_ctrl`

## Requirements
- R1: After reset with a firmware major version (bits 31:28) of 3 or more, the init word at 0x1000 reads 0, `eng_go` is low and `spi_host_sel` is 0, meaning the engine owns the master.
- R2: The word at 0x1004 returns the `fw_version` value sampled while reset is held: patch in bits 23:20, minor in 27:24, major in 31:28.
- R3: With a major version of 3 or more, a host write to 0x1000 with bit 1 (start) set, while start and done are both clear, sets the start bit and raises `eng_go` from the next cycle.
- R4: Bits 23:8 of the init word hold eight 2-bit FEC requests, with link k in bits 9+2k:8+2k (0 none, 1 KR, 2 RS). They read back exactly as written and drive `eng_fec`. They accept host writes only while start and done are both clear; a write in the same cycle that start is accepted is stored.
- R5: A host write of the start bit while start or done is already set has no effect on the init word or on `eng_go`.
- R6: With a nonzero major version below 3, `eng_go` is high as soon as reset is released, the start bit reads 0, and written start bits are ignored.
- R7: With an all-zero version, `spi_host_sel` is 1 from reset, `eng_go` never rises, and the done bit stays 0.
- R8: An `eng_done` pulse while the engine runs sets init bit 0 in the next cycle, drops `eng_go` and sets `spi_host_sel`. An `eng_done` pulse at any other time is ignored.
- R9: Once set, done stays set until reset, and later host writes to the init word change nothing.
- R10: A `stat_we` pulse loads `stat_val` into the status word of retimer `stat_sel`, readable at 0x1020 (retimer 0) or 0x1024 (retimer 1). `init_err` is 1 while either status word is 0x100 or more. Host writes to those addresses are ignored.
- R11: Ownership passes to the host when done sets, even while `init_err` is 1. `eng_go` and `spi_host_sel` are never high together.
- R12: A read of an address outside the four words returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; `fw_version` is sampled while it is low |
| bus_we | input | 1 | Host register write strobe |
| bus_addr | input | 16 | Host register byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fw_version | input | 32 | Firmware version presented by the engine |
| eng_go | output | 1 | Engine may run its configuration |
| eng_fec | output | 16 | Per-link FEC requests handed to the engine |
| eng_done | input | 1 | Engine completion pulse |
| stat_we | input | 1 | Engine status load strobe |
| stat_sel | input | 1 | Retimer whose status word is loaded |
| stat_val | input | 32 | Status value to load |
| init_err | output | 1 | A status word reports an initialization error |
| spi_host_sel | output | 1 | SPI master mux select: 1 host, 0 engine |

## Verification
Two functions can land on the same clock edge: a host write of the FEC fields and the engine's completion pulse. With legacy firmware the bench drives a new FEC pattern and `eng_done` in one cycle. It then expects the new pattern together with done, because the freeze only applies from the following edge. With armed firmware the bench separately drives an error-level status load followed by completion. It judges that ownership still moves to the host while `init_err` stays high.

// File: rtl/hs_pkg.sv
// Package hs_pkg: shared types and fixed field positions for the startup
// handshake controller. Assumes one init word with done and start in the low
// bits and the FEC requests starting at bit 8.
package hs_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_NOFW = 2'd0,   // no firmware: host owns the master, nothing runs
        ST_WAIT = 2'd1,   // armed firmware waiting for the host start bit
        ST_RUN  = 2'd2,   // engine owns the master and configures links
        ST_DONE = 2'd3    // configuration finished, host owns the master
    } hs_state_e;

    // Start-up behaviour chosen from the firmware version
    typedef enum logic [1:0] {
        BOOT_NOFW   = 2'd0,
        BOOT_ARMED  = 2'd1,
        BOOT_LEGACY = 2'd2
    } hs_boot_e;

    // Link FEC request codes
    typedef enum logic [1:0] {
        FEC_NONE = 2'd0,
        FEC_KR   = 2'd1,
        FEC_RS   = 2'd2
    } hs_fec_e;

    localparam int DONE_BIT  = 0;
    localparam int START_BIT = 1;
    localparam int FEC_LSB   = 8;
    localparam int MAJ_LSB   = 28;
    localparam int MAJ_W     = 4;

endpackage

// File: rtl/hs_seq.sv
// Module hs_seq: start/done sequencer. The boot mode, derived from the
// firmware version, is loaded into the state register while reset is held.
// Assumes start_req_i and eng_done_i are single-cycle strobes.
module hs_seq
    import hs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hs_boot_e boot_mode_i,
    input  logic     start_req_i,
    input  logic     eng_done_i,
    output logic     start_o,
    output logic     done_o,
    output logic     go_o,
    output logic     host_sel_o
);

    hs_state_e state_q;
    logic      start_q;

    // State register: reset picks the entry state, then start and done advance it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            case (boot_mode_i)
                BOOT_ARMED:  state_q <= ST_WAIT;
                BOOT_LEGACY: state_q <= ST_RUN;
                default:     state_q <= ST_NOFW;
            endcase
        end else begin
            case (state_q)
                ST_WAIT: if (start_req_i) begin
                    state_q <= ST_RUN;
                    start_q <= 1'b1;
                end
                ST_RUN: if (eng_done_i) state_q <= ST_DONE;
                default: state_q <= state_q;
            endcase
        end
    end

    // Output decode from the current state
    always_comb begin
        start_o    = start_q;
        done_o     = (state_q == ST_DONE);
        go_o       = (state_q == ST_RUN);
        host_sel_o = (state_q == ST_DONE) || (state_q == ST_NOFW);
    end

    // R9: done never clears once set
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    // R8: a completion pulse while running sets done next cycle
    p_done_on_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && eng_done_i) |=> (done_o && host_sel_o));

    // R5: the start bit never falls outside reset
    p_start_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> start_o);

endmodule

// File: rtl/hs_fec_store.sv
// Module hs_fec_store: per-link FEC request registers. Each link keeps the
// raw 2-bit code the host wrote. Writes are dropped while lock_i is high
// (start accepted or done set). Assumes wdata_i is already aligned to link 0.
module hs_fec_store #(
    parameter  int LINKS = 8,
    parameter  int FEC_W = 2,
    localparam int FW    = LINKS * FEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          lock_i,
    input  logic [FW-1:0] wdata_i,
    output logic [FW-1:0] fec_o
);

    genvar g;
    generate
        for (g = 0; g < LINKS; g++) begin : g_link
            logic [FEC_W-1:0] code_q;

            // Link code register: loads from the host write unless locked
            always_ff @(posedge clk) begin
                if (!rst_n)                 code_q <= '0;
                else if (we_i && !lock_i)   code_q <= wdata_i[g*FEC_W +: FEC_W];
            end

            assign fec_o[g*FEC_W +: FEC_W] = code_q;
        end
    endgenerate

    // R4: the requests do not move while locked
    p_fec_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(fec_o));

    // R4: an unlocked write lands exactly as written
    p_fec_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !lock_i) |=> (fec_o == $past(wdata_i)));

endmodule

// File: rtl/hs_stat_bank.sv
// Module hs_stat_bank: one status word per retimer, loaded by the engine.
// Raises err_o while any word is at or above ERR_LIM. Assumes sel_i is
// below RTRS when we_i is high.
module hs_stat_bank #(
    parameter  int              RTRS    = 2,
    parameter  int              DW      = 32,
    parameter  logic [DW-1:0]   ERR_LIM = 32'h100,
    localparam int              SW      = (RTRS > 1) ? $clog2(RTRS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [SW-1:0]        sel_i,
    input  logic [DW-1:0]        val_i,
    output logic [RTRS*DW-1:0]   stat_o,
    output logic                 err_o
);

    logic [RTRS-1:0] over;

    genvar k;
    generate
        for (k = 0; k < RTRS; k++) begin : g_rtr
            logic [DW-1:0] word_q;

            // Status register: loads when the engine addresses this retimer
            always_ff @(posedge clk) begin
                if (!rst_n)                           word_q <= '0;
                else if (we_i && (sel_i == SW'(k)))   word_q <= val_i;
            end

            assign stat_o[k*DW +: DW] = word_q;
            assign over[k]            = (word_q >= ERR_LIM);

            // R10: a load is visible in the next cycle
            p_stat_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && (sel_i == SW'(k))) |=> (stat_o[k*DW +: DW] == $past(val_i)));
        end
    endgenerate

    // Error summary across retimers
    always_comb err_o = |over;

endmodule

// File: rtl/hs_own_ctrl.sv
// Module hs_own_ctrl: top of the startup handshake and SPI ownership
// controller. Decodes the host register window, samples the firmware version
// during reset and ties the sequencer, FEC store and status bank together.
// Assumes fw_version is stable while rst_n is low.
module hs_own_ctrl
    import hs_pkg::*;
#(
    parameter  int             AW        = 16,
    parameter  int             DW        = 32,
    parameter  int             LINKS     = 8,
    parameter  int             FEC_W     = 2,
    parameter  int             RTRS      = 2,
    parameter  logic [AW-1:0]  INIT_ADDR = 16'h1000,
    parameter  logic [AW-1:0]  VER_ADDR  = 16'h1004,
    parameter  logic [AW-1:0]  STAT_BASE = 16'h1020,
    parameter  int             MAJ_ARM   = 3,
    parameter  logic [DW-1:0]  ERR_LIM   = 32'h100,
    localparam int             FW        = LINKS * FEC_W,
    localparam int             SELW      = (RTRS > 1) ? $clog2(RTRS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [DW-1:0]    fw_version,
    output logic             eng_go,
    output logic [FW-1:0]    eng_fec,
    input  logic             eng_done,
    input  logic             stat_we,
    input  logic [SELW-1:0]  stat_sel,
    input  logic [DW-1:0]    stat_val,
    output logic             init_err,
    output logic             spi_host_sel
);

    logic [DW-1:0]       ver_q;
    hs_boot_e            boot_mode;
    logic                init_we;
    logic                start_req;
    logic                start_flag;
    logic                done_flag;
    logic [FW-1:0]       fec_q;
    logic [RTRS*DW-1:0]  stat_words;
    logic [DW-1:0]       init_word;
    logic                unused_wbits;

    // Version capture: follows the engine while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) ver_q <= fw_version;
    end

    // Boot mode from the live version, consumed only inside reset
    always_comb begin
        if (fw_version == '0)
            boot_mode = BOOT_NOFW;
        else if (int'(fw_version[MAJ_LSB +: MAJ_W]) >= MAJ_ARM)
            boot_mode = BOOT_ARMED;
        else
            boot_mode = BOOT_LEGACY;
    end

    // Host write decode for the init word
    always_comb begin
        init_we   = bus_we && (bus_addr == INIT_ADDR);
        start_req = init_we && bus_wdata[START_BIT];
    end

    hs_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_mode_i (boot_mode),
        .start_req_i (start_req),
        .eng_done_i  (eng_done),
        .start_o     (start_flag),
        .done_o      (done_flag),
        .go_o        (eng_go),
        .host_sel_o  (spi_host_sel)
    );

    hs_fec_store #(
        .LINKS (LINKS),
        .FEC_W (FEC_W)
    ) u_fec (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (init_we),
        .lock_i  (start_flag || done_flag),
        .wdata_i (bus_wdata[FEC_LSB +: FW]),
        .fec_o   (fec_q)
    );

    hs_stat_bank #(
        .RTRS    (RTRS),
        .DW      (DW),
        .ERR_LIM (ERR_LIM)
    ) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (stat_we),
        .sel_i  (stat_sel),
        .val_i  (stat_val),
        .stat_o (stat_words),
        .err_o  (init_err)
    );

    assign eng_fec      = fec_q;
    assign unused_wbits = ^{bus_wdata[DW-1:FEC_LSB+FW], bus_wdata[FEC_LSB-1:START_BIT+1],
                            bus_wdata[DONE_BIT]};

    // Init word assembly from flags and link requests
    always_comb begin
        init_word                  = '0;
        init_word[DONE_BIT]        = done_flag;
        init_word[START_BIT]       = start_flag;
        init_word[FEC_LSB +: FW]   = fec_q;
    end

    // Read mux over the register window; unmapped addresses read zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == INIT_ADDR)     bus_rdata = init_word;
        else if (bus_addr == VER_ADDR) bus_rdata = ver_q;
        for (int k = 0; k < RTRS; k++) begin
            if (bus_addr == STAT_BASE + AW'(4 * k)) bus_rdata = stat_words[k*DW +: DW];
        end
    end

    // R11: engine run and host ownership exclude each other
    p_owner_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_go && spi_host_sel));

    // R7: host ownership is never taken back before reset
    p_host_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_host_sel |=> spi_host_sel);

    // R3: an accepted start raises the run level on the next edge
    p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !start_flag && !done_flag && !eng_go && !spi_host_sel) |=> eng_go);

endmodule

// File: tb/sim_hs_own_ctrl.sv
module sim_hs_own_ctrl;

    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] fw_version = '0;
    logic        eng_go;
    logic [15:0] eng_fec;
    logic        eng_done = 1'b0;
    logic        stat_we = 1'b0;
    logic [0:0]  stat_sel = '0;
    logic [31:0] stat_val = '0;
    logic        init_err;
    logic        spi_host_sel;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #(CLK_T/2) clk = ~clk;

    hs_own_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .fw_version   (fw_version),
        .eng_go       (eng_go),
        .eng_fec      (eng_fec),
        .eng_done     (eng_done),
        .stat_we      (stat_we),
        .stat_sel     (stat_sel),
        .stat_val     (stat_val),
        .init_err     (init_err),
        .spi_host_sel (spi_host_sel)
    );

    // Operation codes of the vector table
    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_DN = 2'd2, OP_ST = 2'd3;

    // {op, addr, data, expected read at addr, go, host_sel, err}
    localparam int NV = 12;
    localparam logic [84:0] VEC [NV] = '{
        {OP_RD, 16'h1000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0}, // R1
        {OP_RD, 16'h1004, 32'h0000_0000, 32'h3120_0000, 1'b0, 1'b0, 1'b0}, // R2
        {OP_WR, 16'h1000, 32'h00AA_AA00, 32'h00AA_AA00, 1'b0, 1'b0, 1'b0}, // R4 all RS
        {OP_WR, 16'h1000, 32'h0062_4900, 32'h0062_4900, 1'b0, 1'b0, 1'b0}, // R4 mixed
        {OP_WR, 16'h1000, 32'h0055_5502, 32'h0055_5502, 1'b1, 1'b0, 1'b0}, // R3 start, all KR
        {OP_WR, 16'h1000, 32'h00AA_AA02, 32'h0055_5502, 1'b1, 1'b0, 1'b0}, // R5 second start
        {OP_ST, 16'h1020, 32'h0000_0042, 32'h0000_0042, 1'b1, 1'b0, 1'b0}, // R10 load
        {OP_WR, 16'h1024, 32'h0000_FFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b0}, // R10 host write
        {OP_DN, 16'h1000, 32'h0000_0000, 32'h0055_5503, 1'b0, 1'b1, 1'b0}, // R8 done
        {OP_WR, 16'h1000, 32'h00AA_AA00, 32'h0055_5503, 1'b0, 1'b1, 1'b0}, // R9 write after
        {OP_DN, 16'h1000, 32'h0000_0000, 32'h0055_5503, 1'b0, 1'b1, 1'b0}, // R9 extra pulse
        {OP_RD, 16'h1008, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, 1'b0}  // R12
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [31:0] ver);
        @(negedge clk);
        fw_version = ver;
        rst_n = 1'b0;
        bus_we = 1'b0;
        eng_done = 1'b0;
        stat_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // One bus/engine action, then strobes dropped before the check point
    task automatic step(input logic [1:0] op, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        case (op)
            OP_WR: begin bus_we = 1'b1; bus_wdata = d; end
            OP_DN: eng_done = 1'b1;
            OP_ST: begin stat_we = 1'b1; stat_sel = a[2]; stat_val = d; end
            default: ;
        endcase
        @(posedge clk);
        #2;
        bus_we = 1'b0;
        eng_done = 1'b0;
        stat_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [15:0] a);
        bus_addr = a;
        #1;
    endtask

    initial begin
        #(CLK_T * 100000);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Table walk: armed firmware 3.1.2
        do_reset(32'h3120_0000);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][84:83], VEC[i][82:67], VEC[i][66:35]);
            check($sformatf("vec%0d rdata", i), bus_rdata, VEC[i][34:3]);
            check($sformatf("vec%0d go", i), {31'b0, eng_go}, {31'b0, VEC[i][2]});
            check($sformatf("vec%0d host_sel", i), {31'b0, spi_host_sel}, {31'b0, VEC[i][1]});
            check($sformatf("vec%0d err", i), {31'b0, init_err}, {31'b0, VEC[i][0]});
        end
        check("R4 eng_fec after table", {16'b0, eng_fec}, 32'h0000_5555);

        // R8: done pulse before start is ignored; R10/R11 error still hands over
        do_reset(32'h3000_0000);
        step(OP_DN, 16'h1000, 32'h0);
        check("R8 early done ignored", bus_rdata, 32'h0);
        check("R8 early done owner", {31'b0, spi_host_sel}, 32'h0);
        step(OP_WR, 16'h1000, 32'h0000_0002);
        check("R3 go after start", {31'b0, eng_go}, 32'h1);
        step(OP_ST, 16'h1024, 32'h0000_00FF);
        check("R10 0xFF no error", {31'b0, init_err}, 32'h0);
        check("R10 readback rtr1", bus_rdata, 32'h0000_00FF);
        step(OP_ST, 16'h1024, 32'h0000_0100);
        check("R10 0x100 error", {31'b0, init_err}, 32'h1);
        step(OP_DN, 16'h1000, 32'h0);
        check("R11 owner with error", {31'b0, spi_host_sel}, 32'h1);
        check("R11 done bit", bus_rdata, 32'h0000_0003);
        check("R11 err kept", {31'b0, init_err}, 32'h1);

        // R6: legacy firmware runs without start; same-cycle write and done
        do_reset(32'h2500_0000);
        rd(16'h1000);
        check("R6 go from reset", {31'b0, eng_go}, 32'h1);
        check("R6 init reads zero", bus_rdata, 32'h0);
        rd(16'h1004);
        check("R2 legacy version", bus_rdata, 32'h2500_0000);
        step(OP_WR, 16'h1000, 32'h0055_5502);
        check("R6 start ignored", bus_rdata, 32'h0055_5500);
        @(negedge clk);
        bus_addr = 16'h1000;
        bus_we = 1'b1;
        bus_wdata = 32'h00AA_AA00;
        eng_done = 1'b1;
        @(posedge clk);
        #2;
        bus_we = 1'b0;
        eng_done = 1'b0;
        #1;
        check("R4 R8 same-cycle write and done", bus_rdata, 32'h00AA_AA01);
        check("R8 owner legacy", {31'b0, spi_host_sel}, 32'h1);
        check("R8 go drops", {31'b0, eng_go}, 32'h0);
        step(OP_WR, 16'h1000, 32'h0);
        check("R9 frozen after done", bus_rdata, 32'h00AA_AA01);

        // R7: no firmware
        do_reset(32'h0000_0000);
        rd(16'h1000);
        check("R7 host owns at once", {31'b0, spi_host_sel}, 32'h1);
        check("R7 no go", {31'b0, eng_go}, 32'h0);
        step(OP_WR, 16'h1000, 32'h0000_0002);
        check("R7 start no go", {31'b0, eng_go}, 32'h0);
        check("R7 start bit clear", bus_rdata, 32'h0);
        step(OP_DN, 16'h1000, 32'h0);
        check("R7 done stays clear", bus_rdata, 32'h0);

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule